// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a small in-order integer processor. A fetch stage feeds four pipeline latches: decode with operand read, ALU, data-memory access and writeback. It runs a compact set of eleven operations: register-register and register-immediate add, subtract and multiply, a word load and a word store, two conditional branches that test one register against zero, and an unconditional jump. The instruction memory and data memory are internal word arrays. A load port fills them while reset is held.

Operands reach decode from the register file or through forwarding paths from the three later stages. Branch direction and target are resolved in decode, so a taken branch costs one squashed fetch slot. An instruction that needs the value of a load one position ahead of it waits in decode for exactly one cycle. Every instruction that leaves the last stage raises a retire strobe. The strobe carries the instruction's PC, the register it wrote and the value written, so a bench can compare the core with a model that runs one instruction at a time.

Top module: `pipeCore`

## Requirements
- R1: While `rst` is high, `retireValid` stays low and no instruction advances. The cycle after `rst` falls also shows `retireValid` low. Fetch restarts at byte address 0.
- R2: Instruction word layout is: opcode in bits [31:26], field A in [25:21], field B in [20:16], field C in [15:11], and a 16-bit signed immediate in [15:0]. Opcodes 1, 2 and 3 (add, sub, mul) write A := B op C. Multiply keeps the low 32 bits of the product.
- R3: Opcodes 4, 5 and 6 (add, sub and mul with an immediate) write A := B op sext(imm).
- R4: Opcode 7 loads A := mem[B + sext(imm)]. Opcode 8 stores register B to mem[A + sext(imm)]. The data memory holds 64 words and is indexed by byte-address bits [7:2].
- R5: Opcode 9 branches when register A equals zero and opcode 10 when it is nonzero. Opcode 11 always branches. The target is the branch PC + 4 + sext(imm). Every other instruction advances the PC by 4.
- R6: A taken branch squashes the one instruction fetched behind it. The branch target therefore retires two cycles after the branch.
- R7: A result is forwarded from the ALU stage first, then the memory stage, then the writeback stage, and only then read from the register file. A dependent instruction that does not follow a load retires in the cycle after its producer.
- R8: An instruction retires two cycles after a load, after one bubble, when the load has a nonzero destination and the instruction is next in program order and reads that register. The registers read are: B and C for opcodes 1–3; B for opcodes 4–7; A and B for opcode 8; A for opcodes 9–10.
- R9: There are 8 registers, selected by the low 3 bits of a field. Register 0 reads as zero and writes to it are discarded. An instruction that writes no register retires with destination 0 and value 0.
- R10: Each executed instruction retires exactly once, in program order, with its own PC. Squashed slots never retire.
- R11: The load port has no effect while `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also enables the load port |
| loadEn | input | 1 | Write one memory word during reset |
| loadToData | input | 1 | 1 selects data memory, 0 selects instruction memory |
| loadAddr | input | 6 | Word index for the load write |
| loadData | input | 32 | Word to write |
| retireValid | output | 1 | One instruction leaves writeback this cycle |
| retirePc | output | 32 | Byte PC of the retiring instruction |
| retireDest | output | 3 | Register written, 0 when none |
| retireValue | output | 32 | Value written, 0 when none |

## Verification
The assertions check pipeline invariants on every cycle. A stall always puts a bubble into the ALU stage and keeps the decode occupant and its PC unchanged. A redirect always empties decode. A stall and a redirect never occur together, no instruction retires right after reset, and a retire with no destination always carries a zero value. The bench's scenarios are the only way to show that values are correct under each forwarding distance and that branch conditions and targets are right. They also show the exact one-cycle cost of load-use stalls and taken branches, measured as gaps between retire strobes, and that load-port writes are ignored while the core runs.

// File: rtl/pipePkg.sv
package pipePkg;

  localparam int XLEN = 32;

  typedef enum logic [5:0] {
    OP_NOP  = 6'd0,
    OP_ADD  = 6'd1,
    OP_SUB  = 6'd2,
    OP_MUL  = 6'd3,
    OP_ADDI = 6'd4,
    OP_SUBI = 6'd5,
    OP_MULI = 6'd6,
    OP_LD   = 6'd7,
    OP_ST   = 6'd8,
    OP_BEQZ = 6'd9,
    OP_BNEZ = 6'd10,
    OP_J    = 6'd11
  } opT;

  typedef enum logic [1:0] {FWD_RF, FWD_EX, FWD_MEM, FWD_WB} fwdT;
  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_MUL} aluT;
  typedef enum logic [1:0] {BR_ZERO, BR_NONZERO, BR_ALWAYS} brT;

  // decoded view of the decode-stage occupant
  typedef struct packed {
    logic [4:0] rd1;
    logic [4:0] rd2;
    logic [4:0] dest;
    logic       use1;
    logic       use2;
    logic       writes;
    logic       isLoad;
    logic       isStore;
    logic       isBranch;
    logic       useImm;
    aluT        alu;
    brT         brKind;
  } decT;

  // strobes from control to datapath
  typedef struct packed {
    logic stall;
    logic redirect;
    fwdT  fwd1;
    fwdT  fwd2;
  } ctlT;

endpackage

// File: rtl/pipeCtrl.sv
module pipeCtrl
  import pipePkg::*;
#(
  parameter int NREGS = 8
) (
  input  logic [31:11] dInstr,
  input  logic         dValid,
  input  logic         exValid,
  input  logic [4:0]   exDest,
  input  logic         exWrites,
  input  logic         exIsLoad,
  input  logic         memValid,
  input  logic [4:0]   memDest,
  input  logic         memWrites,
  input  logic         wbValid,
  input  logic [4:0]   wbDest,
  input  logic         wbWrites,
  input  logic         brTaken,
  output decT          dec,
  output ctlT          ctl
);

  localparam logic [4:0] REG_MASK = 5'(NREGS - 1);

  logic [4:0] fA, fB, fC;
  opT         op;

  assign op = opT'(dInstr[31:26]);
  assign fA = dInstr[25:21] & REG_MASK;
  assign fB = dInstr[20:16] & REG_MASK;
  assign fC = dInstr[15:11] & REG_MASK;

  always_comb begin
    dec = '0;
    dec.alu = ALU_ADD;
    dec.brKind = BR_ALWAYS;
    case (op)
      OP_ADD, OP_SUB, OP_MUL: begin
        dec.rd1 = fB; dec.use1 = 1'b1;
        dec.rd2 = fC; dec.use2 = 1'b1;
        dec.dest = fA; dec.writes = (fA != 5'd0);
        dec.alu = (op == OP_ADD) ? ALU_ADD : (op == OP_SUB) ? ALU_SUB : ALU_MUL;
      end
      OP_ADDI, OP_SUBI, OP_MULI: begin
        dec.rd1 = fB; dec.use1 = 1'b1; dec.useImm = 1'b1;
        dec.dest = fA; dec.writes = (fA != 5'd0);
        dec.alu = (op == OP_ADDI) ? ALU_ADD : (op == OP_SUBI) ? ALU_SUB : ALU_MUL;
      end
      OP_LD: begin
        dec.rd1 = fB; dec.use1 = 1'b1; dec.useImm = 1'b1;
        dec.dest = fA; dec.writes = (fA != 5'd0); dec.isLoad = 1'b1;
      end
      OP_ST: begin
        dec.rd1 = fA; dec.use1 = 1'b1;
        dec.rd2 = fB; dec.use2 = 1'b1;
        dec.useImm = 1'b1; dec.isStore = 1'b1;
      end
      OP_BEQZ, OP_BNEZ: begin
        dec.rd1 = fA; dec.use1 = 1'b1; dec.isBranch = 1'b1;
        dec.brKind = (op == OP_BEQZ) ? BR_ZERO : BR_NONZERO;
      end
      OP_J: begin
        dec.isBranch = 1'b1;
      end
      default: ;
    endcase
  end

  function automatic fwdT pickSrc(input logic [4:0] idx, input logic used);
    if (!used || idx == 5'd0)                        return FWD_RF;
    else if (exValid && exWrites && !exIsLoad && exDest == idx) return FWD_EX;
    else if (memValid && memWrites && memDest == idx)  return FWD_MEM;
    else if (wbValid && wbWrites && wbDest == idx)     return FWD_WB;
    else                                               return FWD_RF;
  endfunction

  logic loadHit;

  assign loadHit = exValid && exIsLoad && exWrites &&
                   ((dec.use1 && dec.rd1 == exDest) || (dec.use2 && dec.rd2 == exDest));

  always_comb begin
    ctl.stall    = dValid && loadHit;
    ctl.redirect = dValid && dec.isBranch && brTaken && !ctl.stall;
    ctl.fwd1     = pickSrc(dec.rd1, dec.use1);
    ctl.fwd2     = pickSrc(dec.rd2, dec.use2);
  end

endmodule

// File: rtl/pipeDatapath.sv
module pipeDatapath
  import pipePkg::*;
#(
  parameter int NREGS      = 8,
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int LOAD_AW    = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               loadEn,
  input  logic               loadToData,
  input  logic [LOAD_AW-1:0] loadAddr,
  input  logic [XLEN-1:0]    loadData,
  input  decT                dec,
  input  ctlT                ctl,
  output logic [31:0]        dInstr,
  output logic               dValid,
  output logic [XLEN-1:0]    dPc,
  output logic               exValid,
  output logic [4:0]         exDest,
  output logic               exWrites,
  output logic               exIsLoad,
  output logic               memValid,
  output logic [4:0]         memDest,
  output logic               memWrites,
  output logic               wbValid,
  output logic [4:0]         wbDest,
  output logic               wbWrites,
  output logic               brTaken,
  output logic [XLEN-1:0]    wbPc,
  output logic [XLEN-1:0]    wbVal
);

  localparam int REG_W   = $clog2(NREGS);
  localparam int IMEM_AW = $clog2(IMEM_WORDS);
  localparam int DMEM_AW = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];
  logic [XLEN-1:0] rf   [NREGS];

  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] immExt, brTarget;

  // ALU stage
  logic [XLEN-1:0] exPc, exA, exB, exStData, aluRes;
  logic            exIsStore;
  aluT             exAlu;

  // memory stage
  logic [XLEN-1:0] memPc, memRes, memStData, memRead, memVal;
  logic            memIsLoad, memIsStore;

  // ---------------- memories ----------------
  always_ff @(posedge clk) begin
    if (rst && loadEn && !loadToData)
      imem[loadAddr[IMEM_AW-1:0]] <= loadData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if (loadEn && loadToData)
        dmem[loadAddr[DMEM_AW-1:0]] <= loadData;
    end else if (memValid && memIsStore) begin
      dmem[memRes[DMEM_AW+1:2]] <= memStData;
    end
  end

  assign memRead = dmem[memRes[DMEM_AW+1:2]];
  assign memVal  = memIsLoad ? memRead : memRes;

  // ---------------- register file ----------------
  always_ff @(posedge clk) begin
    if (!rst && wbValid && wbWrites)
      rf[wbDest[REG_W-1:0]] <= wbVal;
  end

  // ---------------- operand read with forwarding ----------------
  logic [4:0]      rdIdx [2];
  fwdT             fSel  [2];
  logic [XLEN-1:0] opVal [2];

  assign rdIdx[0] = dec.rd1;
  assign rdIdx[1] = dec.rd2;
  assign fSel[0]  = ctl.fwd1;
  assign fSel[1]  = ctl.fwd2;

  generate
    for (genvar gp = 0; gp < 2; gp++) begin : gRead
      always_comb begin
        case (fSel[gp])
          FWD_EX:  opVal[gp] = aluRes;
          FWD_MEM: opVal[gp] = memVal;
          FWD_WB:  opVal[gp] = wbVal;
          default: opVal[gp] = (rdIdx[gp] == 5'd0) ? '0 : rf[rdIdx[gp][REG_W-1:0]];
        endcase
      end
    end
  endgenerate

  // ---------------- branch resolution in decode ----------------
  assign immExt   = {{(XLEN-16){dInstr[15]}}, dInstr[15:0]};
  assign brTarget = dPc + 32'd4 + immExt;

  always_comb begin
    case (dec.brKind)
      BR_ZERO:    brTaken = (opVal[0] == '0);
      BR_NONZERO: brTaken = (opVal[0] != '0);
      default:    brTaken = 1'b1;
    endcase
  end

  // ---------------- fetch / decode latch ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      dValid <= 1'b0;
      dInstr <= '0;
      dPc    <= '0;
    end else if (!ctl.stall) begin
      if (ctl.redirect) begin
        pc     <= brTarget;
        dValid <= 1'b0;
        dInstr <= '0;
      end else begin
        pc     <= pc + 32'd4;
        dInstr <= imem[pc[IMEM_AW+1:2]];
        dPc    <= pc;
        dValid <= 1'b1;
      end
    end
  end

  // ---------------- ALU stage latch ----------------
  logic enterEx;
  assign enterEx = !rst && dValid && !ctl.stall;

  always_ff @(posedge clk) begin
    exValid   <= enterEx;
    exWrites  <= enterEx && dec.writes;
    exIsLoad  <= enterEx && dec.isLoad;
    exIsStore <= enterEx && dec.isStore;
    exDest    <= dec.dest;
    exAlu     <= dec.alu;
    exPc      <= dPc;
    exA       <= opVal[0];
    exB       <= dec.useImm ? immExt : opVal[1];
    exStData  <= opVal[1];
  end

  always_comb begin
    case (exAlu)
      ALU_SUB: aluRes = exA - exB;
      ALU_MUL: aluRes = exA * exB;
      default: aluRes = exA + exB;
    endcase
  end

  // ---------------- memory stage latch ----------------
  always_ff @(posedge clk) begin
    memValid   <= !rst && exValid;
    memWrites  <= !rst && exValid && exWrites;
    memIsLoad  <= !rst && exValid && exIsLoad;
    memIsStore <= !rst && exValid && exIsStore;
    memDest    <= exDest;
    memPc      <= exPc;
    memRes     <= aluRes;
    memStData  <= exStData;
  end

  // ---------------- writeback latch ----------------
  always_ff @(posedge clk) begin
    wbValid  <= !rst && memValid;
    wbWrites <= !rst && memValid && memWrites;
    wbDest   <= memWrites ? memDest : 5'd0;
    wbVal    <= memWrites ? memVal : '0;
    wbPc     <= memPc;
  end

endmodule

// File: rtl/pipeCore.sv
module pipeCore
  import pipePkg::*;
#(
  parameter int NREGS      = 8,
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int LOAD_AW    = (IMEM_WORDS > DMEM_WORDS) ? $clog2(IMEM_WORDS) : $clog2(DMEM_WORDS),
  parameter int REG_W      = $clog2(NREGS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               loadEn,
  input  logic               loadToData,
  input  logic [LOAD_AW-1:0] loadAddr,
  input  logic [31:0]        loadData,
  output logic               retireValid,
  output logic [31:0]        retirePc,
  output logic [REG_W-1:0]   retireDest,
  output logic [31:0]        retireValue
);

  decT         dec;
  ctlT         ctl;
  logic [31:0] dInstr, dPc, wbPc, wbVal;
  logic        dValid, exValid, exWrites, exIsLoad;
  logic        memValid, memWrites, wbValid, wbWrites, brTaken;
  logic [4:0]  exDest, memDest, wbDest;
  logic        coreStall, coreRedirect;

  pipeCtrl #(.NREGS(NREGS)) u_ctrl (
    .dInstr   (dInstr[31:11]),
    .dValid   (dValid),
    .exValid  (exValid),
    .exDest   (exDest),
    .exWrites (exWrites),
    .exIsLoad (exIsLoad),
    .memValid (memValid),
    .memDest  (memDest),
    .memWrites(memWrites),
    .wbValid  (wbValid),
    .wbDest   (wbDest),
    .wbWrites (wbWrites),
    .brTaken  (brTaken),
    .dec      (dec),
    .ctl      (ctl)
  );

  pipeDatapath #(
    .NREGS     (NREGS),
    .IMEM_WORDS(IMEM_WORDS),
    .DMEM_WORDS(DMEM_WORDS),
    .LOAD_AW   (LOAD_AW)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .loadEn    (loadEn),
    .loadToData(loadToData),
    .loadAddr  (loadAddr),
    .loadData  (loadData),
    .dec       (dec),
    .ctl       (ctl),
    .dInstr    (dInstr),
    .dValid    (dValid),
    .dPc       (dPc),
    .exValid   (exValid),
    .exDest    (exDest),
    .exWrites  (exWrites),
    .exIsLoad  (exIsLoad),
    .memValid  (memValid),
    .memDest   (memDest),
    .memWrites (memWrites),
    .wbValid   (wbValid),
    .wbDest    (wbDest),
    .wbWrites  (wbWrites),
    .brTaken   (brTaken),
    .wbPc      (wbPc),
    .wbVal     (wbVal)
  );

  assign coreStall    = ctl.stall;
  assign coreRedirect = ctl.redirect;

  assign retireValid = wbValid;
  assign retirePc    = wbPc;
  assign retireDest  = wbDest[REG_W-1:0];
  assign retireValue = wbVal;

endmodule

// File: rtl/pipeCoreChecker.sv
module pipeCoreChecker #(
  parameter int REG_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             retireValid,
  input logic [REG_W-1:0] retireDest,
  input logic [31:0]      retireValue,
  input logic             coreStall,
  input logic             coreRedirect,
  input logic             dValid,
  input logic [31:0]      dPc,
  input logic             exValid
);

  // R1: nothing retires in the first cycle out of reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !retireValid);

  // R8: a stall injects a bubble into the ALU stage
  assert_stall_bubble_R8: assert property (@(posedge clk) disable iff (rst)
    coreStall |=> !exValid);

  // R8: a stall keeps the decode occupant in place
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    coreStall |=> (dValid && $stable(dPc)));

  // R6: a redirect squashes the slot behind the branch
  assert_redirect_squash_R6: assert property (@(posedge clk) disable iff (rst)
    coreRedirect |=> !dValid);

  // R6: a stalled branch is not allowed to redirect
  assert_no_stall_redirect_R6: assert property (@(posedge clk) disable iff (rst)
    !(coreStall && coreRedirect));

  // R9: a retire without a destination carries a zero value
  assert_nodest_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (retireValid && retireDest == '0) |-> (retireValue == '0));

endmodule

bind pipeCore pipeCoreChecker #(.REG_W(REG_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .retireValid (retireValid),
  .retireDest  (retireDest),
  .retireValue (retireValue),
  .coreStall   (coreStall),
  .coreRedirect(coreRedirect),
  .dValid      (dValid),
  .dPc         (dPc),
  .exValid     (exValid)
);

// File: tb/pipeCore_tb.sv
module pipeCore_tb;

  localparam int HALT_IDX = 30;
  localparam logic [31:0] HALT_PC = 32'(HALT_IDX * 4);
  localparam int OP_ADD = 1, OP_SUB = 2, OP_MUL = 3, OP_ADDI = 4, OP_SUBI = 5,
                 OP_MULI = 6, OP_LD = 7, OP_ST = 8, OP_BEQZ = 9, OP_BNEZ = 10, OP_J = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadEn = 1'b0;
  logic        loadToData = 1'b0;
  logic [5:0]  loadAddr = '0;
  logic [31:0] loadData = '0;
  logic        retireValid;
  logic [31:0] retirePc;
  logic [2:0]  retireDest;
  logic [31:0] retireValue;

  always #4 clk = ~clk;

  pipeCore u_dut (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadToData(loadToData),
    .loadAddr(loadAddr), .loadData(loadData), .retireValid(retireValid),
    .retirePc(retirePc), .retireDest(retireDest), .retireValue(retireValue)
  );

  typedef struct {
    logic [31:0] pc;
    logic [2:0]  dest;
    logic [31:0] value;
    int          gap;
    string       tag;
    string       gapTag;
  } itemT;

  itemT        expQ[$];
  itemT        cur;
  logic [31:0] mImem [64];
  logic [31:0] mDinit [64];
  logic [31:0] mDmem [64];
  logic [31:0] mRf [8];
  int nChecks = 0, nFails = 0;
  int cycle = 0, lastCycle = -1;
  bit monOn = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] encR(int op, int d, int s1, int s2);
    return {6'(op), 5'(d), 5'(s1), 5'(s2), 11'd0};
  endfunction

  function automatic logic [31:0] encI(int op, int a, int b, int imm);
    return {6'(op), 5'(a), 5'(b), 16'(imm)};
  endfunction

  task automatic buildProgram();
    for (int i = 0; i < 64; i++) mImem[i] = encI(OP_J, 0, 0, -4);
    mImem[0]  = encI(OP_ADDI, 1, 0, 5);
    mImem[1]  = encI(OP_ADDI, 2, 0, -3);
    mImem[2]  = encR(OP_ADD, 3, 1, 2);
    mImem[3]  = encR(OP_SUB, 4, 3, 1);
    mImem[4]  = encR(OP_MUL, 5, 4, 2);
    mImem[5]  = encI(OP_MULI, 6, 5, 7);
    mImem[6]  = encI(OP_SUBI, 7, 6, 100);
    mImem[7]  = encI(OP_ADDI, 4, 0, 64);
    mImem[8]  = encI(OP_ST, 4, 7, -4);
    mImem[9]  = encI(OP_LD, 1, 4, -4);
    mImem[10] = encR(OP_ADD, 2, 1, 1);
    mImem[11] = encI(OP_ADDI, 0, 2, 9);
    mImem[12] = encR(OP_ADD, 3, 0, 2);
    mImem[13] = encI(OP_LD, 5, 0, 12);
    mImem[14] = encI(OP_BEQZ, 5, 0, 4);
    mImem[15] = encI(OP_BNEZ, 5, 0, 4);
    mImem[16] = encI(OP_ADDI, 7, 0, 111);
    mImem[17] = encI(OP_ADDI, 6, 0, 3);
    mImem[18] = encI(OP_SUBI, 6, 6, 1);
    mImem[19] = encI(OP_BNEZ, 6, 0, -8);
    mImem[20] = encI(OP_BEQZ, 0, 0, 4);
    mImem[21] = encI(OP_ADDI, 7, 0, 222);
    mImem[22] = encI(OP_J, 0, 0, 0);
    mImem[23] = encI(OP_LD, 0, 0, 12);
    mImem[24] = encR(OP_ADD, 1, 0, 0);
    mImem[25] = encI(OP_LD, 2, 0, 16);
    mImem[26] = encI(OP_ST, 4, 2, -8);
    mImem[27] = encI(OP_LD, 3, 4, -8);
    mImem[28] = encR(OP_MUL, 7, 3, 3);
    mImem[29] = encR(OP_SUB, 1, 0, 7);
    for (int i = 0; i < 64; i++) mDinit[i] = 32'h100 + 32'(i * 3);
  endtask

  // instruction-at-a-time model; fills the scoreboard
  task automatic runModel();
    logic [31:0] pc = '0;
    int steps = 0, prevLd = 0;
    bit prevTk = 1'b0, first = 1'b1;
    for (int i = 0; i < 8; i++) mRf[i] = '0;
    for (int i = 0; i < 64; i++) mDmem[i] = mDinit[i];
    while (pc != HALT_PC && steps < 500) begin
      logic [31:0] ins, imm, addr, v, nextPc;
      int op, fa, fb, fc, r1, r2;
      bit u1, u2, wr, tk, stallHit;
      itemT it;
      ins = mImem[pc[7:2]];
      op = int'(ins[31:26]); fa = int'(ins[23:21]); fb = int'(ins[18:16]); fc = int'(ins[13:11]);
      imm = {{16{ins[15]}}, ins[15:0]};
      u1 = 0; u2 = 0; r1 = 0; r2 = 0; wr = 0; tk = 0; v = '0; nextPc = pc + 4;
      it.tag = "R2";
      case (op)
        OP_ADD, OP_SUB, OP_MUL: begin
          u1 = 1; r1 = fb; u2 = 1; r2 = fc; wr = 1;
          v = (op == OP_ADD) ? mRf[fb] + mRf[fc] : (op == OP_SUB) ? mRf[fb] - mRf[fc] : mRf[fb] * mRf[fc];
        end
        OP_ADDI, OP_SUBI, OP_MULI: begin
          u1 = 1; r1 = fb; wr = 1; it.tag = "R3";
          v = (op == OP_ADDI) ? mRf[fb] + imm : (op == OP_SUBI) ? mRf[fb] - imm : mRf[fb] * imm;
        end
        OP_LD: begin
          u1 = 1; r1 = fb; wr = 1; it.tag = "R4";
          addr = mRf[fb] + imm; v = mDmem[addr[7:2]];
        end
        OP_ST: begin
          u1 = 1; r1 = fa; u2 = 1; r2 = fb; it.tag = "R4";
          addr = mRf[fa] + imm; mDmem[addr[7:2]] = mRf[fb];
        end
        OP_BEQZ, OP_BNEZ, OP_J: begin
          it.tag = "R5";
          if (op != OP_J) begin u1 = 1; r1 = fa; end
          tk = (op == OP_J) ? 1'b1 : (op == OP_BEQZ) ? (mRf[fa] == 0) : (mRf[fa] != 0);
          if (tk) nextPc = pc + 4 + imm;
        end
        default: ;
      endcase
      if (wr && fa != 0) begin
        mRf[fa] = v; it.dest = 3'(fa); it.value = v;
      end else begin
        if (wr) it.tag = "R9";
        it.dest = '0; it.value = '0;
      end
      stallHit = (prevLd != 0) && ((u1 && r1 == prevLd) || (u2 && r2 == prevLd));
      it.pc = pc;
      it.gap = first ? 0 : 1 + int'(stallHit) + int'(prevTk);
      it.gapTag = stallHit ? "R8" : prevTk ? "R6" : "R7";
      expQ.push_back(it);
      prevLd = (op == OP_LD) ? fa : 0;
      prevTk = tk; first = 0; pc = nextPc; steps++;
    end
  endtask

  // monitor: pops the scoreboard on every retire
  always @(negedge clk) begin
    cycle++;
    if (monOn && !rst && retireValid && retirePc != HALT_PC) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10", "unexpected retire pc", retirePc, HALT_PC);
      end else begin
        cur = expQ.pop_front();
        check(retirePc == cur.pc, "R10", "retire pc", retirePc, cur.pc);
        check(retireDest == cur.dest, cur.tag, "retire dest", 32'(retireDest), 32'(cur.dest));
        check(retireValue == cur.value, cur.tag, "retire value", retireValue, cur.value);
        if (cur.gap > 0 && lastCycle >= 0)
          check(cycle - lastCycle == cur.gap, cur.gapTag, "retire spacing",
                32'(cycle - lastCycle), 32'(cur.gap));
        lastCycle = cycle;
      end
    end
  end

  task automatic doRun(input bit withJunk);
    int t = 0;
    rst = 1'b1; monOn = 1'b0;
    repeat (2) @(negedge clk);
    check(retireValid == 1'b0, "R1", "retire during reset", 32'(retireValid), 0);
    for (int i = 0; i < 64; i++) begin
      loadEn = 1'b1; loadToData = 1'b0; loadAddr = 6'(i); loadData = mImem[i];
      @(negedge clk);
    end
    for (int i = 0; i < 64; i++) begin
      loadEn = 1'b1; loadToData = 1'b1; loadAddr = 6'(i); loadData = mDinit[i];
      @(negedge clk);
    end
    loadEn = 1'b0;
    check(retireValid == 1'b0, "R1", "retire during preload", 32'(retireValid), 0);
    runModel();
    lastCycle = -1;
    rst = 1'b0; monOn = 1'b1;
    @(negedge clk);
    check(retireValid == 1'b0, "R1", "retire right after reset", 32'(retireValid), 0);
    if (withJunk) begin
      // R11: these writes would change the flow and a loaded value if honoured
      for (int k = 0; k < 6; k++) begin
        loadEn = 1'b1;
        loadToData = k[0];
        loadAddr = k[0] ? 6'd3 : 6'd17;
        loadData = k[0] ? 32'd0 : encI(OP_ADDI, 6, 0, 9);
        @(negedge clk);
      end
      loadEn = 1'b0;
    end
    while (expQ.size() > 0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 3000) check(1'b0, "R10", "watchdog expired, items left", 32'(expQ.size()), 0);
    repeat (10) @(negedge clk);
    monOn = 1'b0;
  endtask

  initial begin
    buildProgram();
    doRun(1'b1);   // R11 exercised here
    doRun(1'b0);   // R1: reset mid-run restarts from address 0
    check(expQ.size() == 0, "R10", "scoreboard drained", 32'(expQ.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #1_000_000;
    nChecks++; nFails++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule